// File: doc/BRIEF.md
# Streaming Online-Softmax Attention Accumulator

This block produces exact softmax-weighted attention for a single query row while the row's keys arrive as a stream of blocks. Each accepted element carries one score (the query-key dot product) and the value vector that belongs to it. The full score row is never held. The block keeps three pieces of state: the largest scaled score seen so far, a normalizer referred to that maximum, and a vector accumulator. When a block brings a larger maximum, the old normalizer and the accumulator are rescaled by exp(old_max - new_max) before the block's own contribution is added.

A block is buffered in a small store so that its local maximum is known. The block's exponentials are then computed relative to that local maximum, and the block is merged into the running state in one step. Once the block flagged as last has been merged, the accumulator is divided by the normalizer, one lane per cycle. The output vector is then presented once, with a one-cycle done pulse, together with the final maximum and normalizer. A downstream gradient step can reuse that maximum and normalizer. All arithmetic is fixed point. The exponential comes from a computed lookup table over [-8, 0] with linear interpolation.

Top module: `softmax_stream_acc`

## Requirements
- R1: After reset, done is low and in_ready is high.
- R2: Every score is multiplied by 1/sqrt(DK) before use, as scaled = (score * INV) >>> 16 with INV = floor(65536/sqrt(DK)). Scores are signed with FRAC = 8 fractional bits, and the default DK = 4 gives score >>> 1.
- R3: out_max equals the largest scaled score of the row.
- R4: out_norm is unsigned with 16 fractional bits. It equals the sum over the row of exp((s_i - max)/256), within 700 LSB per element plus 8, and is never below 1.0 (65536).
- R5: Lane k of out_vec (bits k*VW up to k*VW+VW-1, the same lane layout as in_value) equals the sum of p_i * v_i,k with p_i = exp((s_i - max)/256) / sum, within 3% of the largest |v| plus 4.
- R6: done is high for exactly one cycle, once per row. This happens only after the element carrying in_last_blk has been accepted, and no done pulse appears at any other time.
- R7: A block whose maximum exceeds the running maximum rescales the earlier state, and the row result meets R3 to R5.
- R8: A block whose maximum is below the running maximum leaves out_max at the earlier maximum, and the row result meets R3 to R5.
- R9: In the cycle after an element flagged last-in-block is accepted, in_ready is low. An element presented while in_ready is low is not consumed.
- R10: A block that reaches DEPTH elements ends without the last-in-block flag (in_ready is low in the next cycle), and the row result is unaffected.
- R11: An exponential argument below -8.0 yields exactly zero. For a row of two elements whose scaled scores differ by more than 2048 LSB, out_norm is exactly 65536 and out_vec equals the value vector of the larger score exactly.
- R12: For a single-element row, the initial state contributes nothing: out_norm is exactly 65536 and out_vec equals the element's value vector exactly.
- R13: Consecutive rows are independent. The state is cleared when a row is emitted, so each row's results depend only on its own elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Element present on in_score / in_value |
| in_ready | output | 1 | Block can accept an element this cycle |
| in_score | input | SW | Signed score, FRAC fractional bits |
| in_value | input | D*VW | Value vector, lane k at bits k*VW upward, signed |
| in_last_elem | input | 1 | Element closes its block |
| in_last_blk | input | 1 | Element closes the row |
| done | output | 1 | One-cycle pulse, outputs valid |
| out_vec | output | D*VW | Normalized attention output, same lane layout |
| out_max | output | SW | Final running maximum of scaled scores |
| out_norm | output | 17+clog2(ROW_MAX) | Final normalizer, 16 fractional bits |

## Verification
The rescale path matters only when a later block's maximum rises above the running one, and its failure shows up only as a small numeric drift. The stimulus therefore orders blocks so that the maximum rises in one row and falls in another, and the bench compares against a two-pass reference softmax. The zero-contribution behaviour of the initial state and of very negative arguments cannot be told apart from rounding under a tolerance. It is reached with a single-element row and a two-element row whose scores lie more than eight units apart, where results must be exact. A row longer than the block store without an intermediate block flag exercises the forced block end.

// File: rtl/oss_pkg.sv
package oss_pkg;
   localparam int QB  = 16;          // fraction bits of exponentials and normalizer
   localparam int EW  = QB + 1;      // width holding 0 .. 1.0
   localparam int ONE = 1 << QB;

   typedef enum logic [1:0] {
      ST_FILL,
      ST_EXP,
      ST_MERGE,
      ST_DIV
   } st_e;
endpackage

// File: rtl/oss_scale.sv
module oss_scale #(
   parameter int SW = 16,
   parameter int DK = 4
) (
   input  logic signed [SW-1:0] x,
   output logic signed [SW-1:0] y
);
   function automatic longint inv_root(input int dk);
      longint r, t;
      r = 0;
      for (int b = 16; b >= 0; b--) begin
         t = r | (longint'(1) << b);
         if (t * t * longint'(dk) <= (longint'(1) << 32)) r = t;
      end
      return r;
   endfunction

   localparam longint INV = inv_root(DK);

   generate
      if (DK == 1) begin : g_pass
         assign y = x;
      end else begin : g_mul
         logic signed [SW+17:0] p;
         logic signed [17:0]    k_inv;
         assign k_inv = 18'(INV);
         assign p     = (SW+18)'(x) * (SW+18)'(k_inv);
         assign y     = SW'(p >>> 16);
      end
   endgenerate
endmodule

// File: rtl/oss_exp.sv
module oss_exp
   import oss_pkg::*;
#(
   parameter int XW     = 17,
   parameter int FRAC   = 8,
   parameter int SEG_SH = 6,
   parameter int NSEG   = 32
) (
   input  logic [XW-1:0] x,     // signed argument, expected <= 0
   output logic [EW-1:0] y      // exp(x), QB fraction bits
);
   localparam int IW  = $clog2(NSEG + 1);
   localparam int LIM = NSEG << SEG_SH;

   function automatic longint step_q16();
      longint sum, term;
      sum  = longint'(1) << 32;
      term = sum;
      for (int k = 1; k < 16; k++) begin
         term = -(term * (longint'(1) << SEG_SH)) / (longint'(k) << FRAC);
         sum  = sum + term;
      end
      return (sum + (longint'(1) << 15)) >>> 16;
   endfunction

   localparam longint E_STEP = step_q16();

   function automatic logic [EW-1:0] tab_val(input int k);
      longint v;
      v = longint'(ONE);
      for (int i = 0; i < k; i++) v = (v * E_STEP + (longint'(1) << (QB - 1))) >>> QB;
      return EW'(v);
   endfunction

   logic [EW-1:0] tbl [NSEG+1];
   for (genvar k = 0; k <= NSEG; k++) begin : g_tab
      assign tbl[k] = tab_val(k);
   end

   logic [XW-1:0] u;
   logic          in_rng;
   logic [IW-1:0] idx_c;
   logic [EW-1:0] lo, hi;

   assign u      = x[XW-1] ? ({XW{1'b0}} - x) : '0;
   assign in_rng = (u < XW'(LIM));
   assign idx_c  = in_rng ? IW'(u >> SEG_SH) : '0;
   assign lo     = tbl[idx_c];
   assign hi     = tbl[idx_c + IW'(1)];

   generate
      if (SEG_SH == 0) begin : g_step
         assign y = in_rng ? lo : '0;
      end else begin : g_lin
         logic [SEG_SH-1:0]    fr;
         logic [EW+SEG_SH-1:0] prod;
         assign fr   = u[SEG_SH-1:0];
         assign prod = (EW+SEG_SH)'(lo - hi) * (EW+SEG_SH)'(fr);
         assign y    = in_rng ? (lo - EW'(prod >> SEG_SH)) : '0;
      end
   endgenerate
endmodule

// File: rtl/oss_blk_store.sv
module oss_blk_store #(
   parameter int SW    = 16,
   parameter int VW    = 16,
   parameter int D     = 4,
   parameter int DEPTH = 4
) (
   input  logic                   clk,
   input  logic                   wr_en,
   input  logic [AW-1:0]          wr_idx,
   input  logic [SW-1:0]          wr_s,
   input  logic [D*VW-1:0]        wr_v,
   input  logic [AW-1:0]          rd_idx,
   output logic [SW-1:0]          rd_s,
   output logic [D*VW-1:0]        rd_v
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [SW-1:0]   s_mem [DEPTH];
   logic [D*VW-1:0] v_mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         s_mem[wr_idx] <= wr_s;
         v_mem[wr_idx] <= wr_v;
      end
   end

   assign rd_s = s_mem[rd_idx];
   assign rd_v = v_mem[rd_idx];
endmodule

// File: rtl/softmax_stream_acc.sv
module softmax_stream_acc
   import oss_pkg::*;
#(
   parameter int SW      = 16,
   parameter int FRAC    = 8,
   parameter int VW      = 16,
   parameter int D       = 4,
   parameter int DEPTH   = 4,
   parameter int ROW_MAX = 64,
   parameter int DK      = 4,
   parameter int SEG_SH  = 6,
   parameter int NSEG    = 32
) (
   input  logic                              clk,
   input  logic                              rst,
   input  logic                              in_valid,
   output logic                              in_ready,
   input  logic [SW-1:0]                     in_score,
   input  logic [D*VW-1:0]                   in_value,
   input  logic                              in_last_elem,
   input  logic                              in_last_blk,
   output logic                              done,
   output logic [D*VW-1:0]                   out_vec,
   output logic [SW-1:0]                     out_max,
   output logic [EW+$clog2(ROW_MAX)-1:0]     out_norm
);
   localparam int LW   = EW + $clog2(ROW_MAX);
   localparam int ACCW = VW + EW + $clog2(ROW_MAX) + 1;
   localparam int MW   = ACCW + EW + 1;
   localparam int NW   = LW + EW;
   localparam int PW   = $clog2(DEPTH + 1);
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int DW   = (D > 1) ? $clog2(D) : 1;
   localparam int DIFW = SW + 1;
   localparam logic signed [SW-1:0] MINS = {1'b1, {(SW-1){1'b0}}};

   if (DEPTH < 2)           begin : g_chk_depth $error("DEPTH must be at least 2"); end
   if (D < 1)               begin : g_chk_lanes $error("D must be at least 1"); end
   if (DK < 1)              begin : g_chk_dk    $error("DK must be at least 1"); end
   if (ROW_MAX < DEPTH)     begin : g_chk_row   $error("ROW_MAX below DEPTH"); end
   if (SEG_SH + FRAC > 24)  begin : g_chk_seg   $error("exp segment too wide"); end

   st_e                     st_q;
   logic [PW-1:0]           cnt_q, rd_q;
   logic [DW-1:0]           dsel_q;
   logic signed [SW-1:0]    bmax_q, rmax_q, omax_q;
   logic                    last_row_q, done_q;
   logic [LW-1:0]           lblk_q, rl_q, onorm_q;
   logic signed [ACCW-1:0]  accb_q [D];
   logic signed [ACCW-1:0]  acc_q  [D];
   logic [D*VW-1:0]         ovec_q;

   logic                    fire, blk_end;
   logic signed [SW-1:0]    s_scl, rd_s, mnew;
   logic [D*VW-1:0]         rd_v;
   logic signed [DIFW-1:0]  x_el, x_old, x_blk;
   logic [EW-1:0]           e_el, e_old, e_blk;
   logic signed [ACCW-1:0]  acc_mg [D];
   logic signed [ACCW-1:0]  ev     [D];
   logic [LW-1:0]           rl_mg;
   logic signed [ACCW-1:0]  quot;

   assign in_ready = (st_q == ST_FILL);
   assign fire     = in_valid & in_ready;
   assign blk_end  = fire & (in_last_elem | (cnt_q == PW'(DEPTH - 1)));

   oss_scale #(.SW(SW), .DK(DK)) u_scale (.x(in_score), .y(s_scl));

   oss_blk_store #(.SW(SW), .VW(VW), .D(D), .DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .wr_en (fire),
      .wr_idx(AW'(cnt_q)),
      .wr_s  (s_scl),
      .wr_v  (in_value),
      .rd_idx(AW'(rd_q)),
      .rd_s  (rd_s),
      .rd_v  (rd_v)
   );

   // exponentials: per element against the block maximum, and the two merge factors
   assign mnew  = (rmax_q > bmax_q) ? rmax_q : bmax_q;
   assign x_el  = DIFW'(rd_s)   - DIFW'(bmax_q);
   assign x_old = DIFW'(rmax_q) - DIFW'(mnew);
   assign x_blk = DIFW'(bmax_q) - DIFW'(mnew);

   oss_exp #(.XW(DIFW), .FRAC(FRAC), .SEG_SH(SEG_SH), .NSEG(NSEG)) u_exp_el  (.x(x_el),  .y(e_el));
   oss_exp #(.XW(DIFW), .FRAC(FRAC), .SEG_SH(SEG_SH), .NSEG(NSEG)) u_exp_old (.x(x_old), .y(e_old));
   oss_exp #(.XW(DIFW), .FRAC(FRAC), .SEG_SH(SEG_SH), .NSEG(NSEG)) u_exp_blk (.x(x_blk), .y(e_blk));

   always_comb begin
      logic [NW-1:0] nl;
      for (int k = 0; k < D; k++) begin
         logic signed [EW+VW:0] evp;
         logic signed [MW-1:0]  mp;
         evp = (EW+VW+1)'($signed({1'b0, e_el})) * (EW+VW+1)'($signed(rd_v[k*VW +: VW]));
         ev[k] = ACCW'(evp);
         mp = MW'($signed({1'b0, e_old})) * MW'(acc_q[k])
            + MW'($signed({1'b0, e_blk})) * MW'(accb_q[k]);
         acc_mg[k] = ACCW'(mp >>> QB);
      end
      nl    = NW'(e_old) * NW'(rl_q) + NW'(e_blk) * NW'(lblk_q);
      rl_mg = LW'(nl >> QB);
      quot  = acc_q[dsel_q] / $signed(ACCW'(rl_q));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q       <= ST_FILL;
         cnt_q      <= '0;
         rd_q       <= '0;
         dsel_q     <= '0;
         bmax_q     <= MINS;
         rmax_q     <= MINS;
         last_row_q <= 1'b0;
         lblk_q     <= '0;
         rl_q       <= '0;
         done_q     <= 1'b0;
         omax_q     <= '0;
         onorm_q    <= '0;
         ovec_q     <= '0;
         for (int k = 0; k < D; k++) begin
            accb_q[k] <= '0;
            acc_q[k]  <= '0;
         end
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_FILL: if (fire) begin
               cnt_q <= cnt_q + PW'(1);
               if (cnt_q == '0 || s_scl > bmax_q) bmax_q <= s_scl;
               if (blk_end) begin
                  last_row_q <= in_last_blk;
                  rd_q       <= '0;
                  st_q       <= ST_EXP;
               end
            end
            ST_EXP: begin
               lblk_q <= lblk_q + LW'(e_el);
               for (int k = 0; k < D; k++) accb_q[k] <= accb_q[k] + ev[k];
               rd_q <= rd_q + PW'(1);
               if (rd_q == cnt_q - PW'(1)) st_q <= ST_MERGE;
            end
            ST_MERGE: begin
               rmax_q <= mnew;
               rl_q   <= rl_mg;
               for (int k = 0; k < D; k++) begin
                  acc_q[k]  <= acc_mg[k];
                  accb_q[k] <= '0;
               end
               lblk_q <= '0;
               cnt_q  <= '0;
               dsel_q <= '0;
               st_q   <= last_row_q ? ST_DIV : ST_FILL;
            end
            ST_DIV: begin
               ovec_q[dsel_q*VW +: VW] <= quot[VW-1:0];
               if (dsel_q == DW'(D - 1)) begin
                  done_q  <= 1'b1;
                  omax_q  <= rmax_q;
                  onorm_q <= rl_q;
                  rmax_q  <= MINS;
                  rl_q    <= '0;
                  for (int k = 0; k < D; k++) acc_q[k] <= '0;
                  dsel_q  <= '0;
                  st_q    <= ST_FILL;
               end else begin
                  dsel_q <= dsel_q + DW'(1);
               end
            end
            default: st_q <= ST_FILL;
         endcase
      end
   end

   assign done     = done_q;
   assign out_vec  = ovec_q;
   assign out_max  = omax_q;
   assign out_norm = onorm_q;

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R6
   AST_NORM_FLOOR: assert property (@(posedge clk) disable iff (rst) done |-> out_norm >= LW'(ONE)); // R4
   AST_MAX_RISES: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_MERGE) |=> (rmax_q >= $past(rmax_q) && rmax_q >= $past(bmax_q))); // R7
   AST_MAX_KEPT: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_MERGE && rmax_q >= bmax_q) |=> rmax_q == $past(rmax_q)); // R8
   AST_BLOCK_CAP: assert property (@(posedge clk) disable iff (rst) cnt_q <= PW'(DEPTH)); // R10
   AST_FORCED_END: assert property (@(posedge clk) disable iff (rst)
      (fire && cnt_q == PW'(DEPTH - 1)) |=> !in_ready); // R10
   AST_FLAG_END: assert property (@(posedge clk) disable iff (rst)
      (fire && in_last_elem) |=> !in_ready); // R9
   AST_ELEM_ARG: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_EXP) |-> x_el <= 0); // R11
   AST_EXP_CEIL: assert property (@(posedge clk) disable iff (rst)
      (e_el <= EW'(ONE)) && (e_old <= EW'(ONE)) && (e_blk <= EW'(ONE))); // R11
endmodule

// File: tb/softmax_stream_acc_bench.sv
`timescale 1ns/1ps
module softmax_stream_acc_bench;
   localparam int SW = 16, VW = 16, D = 4, DEPTH = 4, LW = 23;

   logic              clk = 1'b0;
   logic              rst;
   logic              in_valid, in_ready, in_last_elem, in_last_blk, done;
   logic [SW-1:0]     in_score, out_max;
   logic [D*VW-1:0]   in_value, out_vec;
   logic [LW-1:0]     out_norm;

   softmax_stream_acc u_softmax_stream_acc (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_score(in_score), .in_value(in_value), .in_last_elem(in_last_elem),
      .in_last_blk(in_last_blk), .done(done), .out_vec(out_vec),
      .out_max(out_max), .out_norm(out_norm)
   );

   always #2.5 clk = ~clk;

   int    total = 0, bad = 0;
   int    sc [16];
   int    vv [16][D];
   bit    expect_done = 1'b0;
   bit    e_exact;
   int    e_max, e_n, e_tolv, e_arg;
   real   e_norm;
   real   e_vec [D];
   string e_tag;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint got, input longint expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, expv);
      end
   endtask

   function automatic int scale_ref(input int s);
      int inv;
      inv = $rtoi($floor(65536.0 / $sqrt(4.0)));   // R2: DK = 4
      return (s * inv) >>> 16;
   endfunction

   // per-clock comparison: done only when a row has been closed, results vs two-pass reference
   always @(negedge clk) begin
      if (!rst && done) begin
         if (!expect_done) begin
            chk(1'b0, "R6", "unexpected done", 1, 0);
         end else begin
            expect_done = 1'b0;
            chk($signed(out_max) == e_max, {e_tag, " R3 R2"}, "out_max", $signed(out_max), e_max);
            if (e_exact) begin
               chk(out_norm == LW'(65536), {e_tag, " R4"}, "out_norm exact", out_norm, 65536);
               for (int k = 0; k < D; k++)
                  chk($signed(out_vec[k*VW +: VW]) == vv[e_arg][k], {e_tag, " R5"}, "lane exact",
                      $signed(out_vec[k*VW +: VW]), vv[e_arg][k]);
            end else begin
               int en;
               en = $rtoi(e_norm * 65536.0 + 0.5);
               chk((int'(out_norm) - en <= e_n * 700 + 8) && (en - int'(out_norm) <= e_n * 700 + 8),
                   {e_tag, " R4"}, "out_norm", out_norm, en);
               for (int k = 0; k < D; k++) begin
                  int ev, gv;
                  ev = $rtoi(e_vec[k] + ((e_vec[k] < 0.0) ? -0.5 : 0.5));
                  gv = $signed(out_vec[k*VW +: VW]);
                  chk((gv - ev <= e_tolv) && (ev - gv <= e_tolv), {e_tag, " R5"}, "lane", gv, ev);
               end
            end
         end
      end
   end

   task automatic fill_vals(input int n, input int seed);
      for (int i = 0; i < n; i++)
         for (int k = 0; k < D; k++)
            vv[i][k] = (((i * 37 + k * 113 + seed * 11) % 401) - 200) * 5;
   endtask

   task automatic send_row(input int n, input int mask, input string tag, input bit exact);
      int  m, bc, maxabs;
      real w;
      real acc [D];
      m = -100000; maxabs = 0; e_norm = 0.0; e_arg = 0;
      for (int i = 0; i < n; i++)
         if (scale_ref(sc[i]) > m) begin m = scale_ref(sc[i]); e_arg = i; end
      for (int k = 0; k < D; k++) acc[k] = 0.0;
      for (int i = 0; i < n; i++) begin
         w = $exp(real'(scale_ref(sc[i]) - m) / 256.0);
         e_norm += w;
         for (int k = 0; k < D; k++) begin
            acc[k] += w * vv[i][k];
            if (vv[i][k] > maxabs) maxabs = vv[i][k];
            if (-vv[i][k] > maxabs) maxabs = -vv[i][k];
         end
      end
      for (int k = 0; k < D; k++) e_vec[k] = acc[k] / e_norm;
      e_max = m; e_n = n; e_tag = tag; e_exact = exact;
      e_tolv = (maxabs * 3) / 100 + 4;
      bc = 0;
      for (int i = 0; i < n; i++) begin
         bit last_e;
         last_e       = mask[i] || (i == n - 1);
         in_valid     = 1'b1;
         in_score     = SW'(sc[i]);
         for (int k = 0; k < D; k++) in_value[k*VW +: VW] = VW'(vv[i][k]);
         in_last_elem = last_e;
         in_last_blk  = (i == n - 1);
         while (!in_ready) @(negedge clk);
         @(negedge clk);
         in_valid = 1'b0;
         bc++;
         if (last_e || bc == DEPTH) begin
            chk(in_ready == 1'b0, (bc == DEPTH && !last_e) ? "R10" : "R9",
                "in_ready after block end", in_ready, 0);
            bc = 0;
         end
         if (i == n - 1) expect_done = 1'b1;
      end
      for (int t = 0; t < 300 && expect_done; t++) @(negedge clk);
      if (expect_done) begin
         chk(1'b0, {tag, " R6"}, "no done", 0, 1);
         expect_done = 1'b0;
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic summary;
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: got 0 expected 1");
      summary();
      $finish;
   end

   initial begin
      rst = 1'b1; in_valid = 1'b0; in_score = '0; in_value = '0;
      in_last_elem = 1'b0; in_last_blk = 1'b0;
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(done == 1'b0, "R1", "done after reset", done, 0);
      chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

      // R12 single element, exact
      fill_vals(1, 1); sc[0] = 300; vv[0][0] = -700;
      send_row(1, 0, "R12", 1'b1);

      // single block of four
      fill_vals(4, 2); sc[0] = 100; sc[1] = -200; sc[2] = 340; sc[3] = 50;
      send_row(4, 'b1000, "R5", 1'b0);

      // R7 second block raises the maximum
      fill_vals(5, 3); sc[0] = -100; sc[1] = 20; sc[2] = 500; sc[3] = 10; sc[4] = -30;
      send_row(5, 'b10010, "R7", 1'b0);

      // R8 later blocks below the running maximum
      fill_vals(5, 4); sc[0] = 600; sc[1] = 100; sc[2] = 200; sc[3] = -50; sc[4] = 300;
      send_row(5, 'b11010, "R8", 1'b0);

      // R10 six elements, block store forces a boundary after four
      fill_vals(6, 5); sc[0] = 40; sc[1] = 90; sc[2] = -60; sc[3] = 10; sc[4] = 150; sc[5] = 70;
      send_row(6, 0, "R10", 1'b0);

      // R11 element far below the maximum contributes exactly nothing
      fill_vals(2, 6); sc[0] = -3000; sc[1] = 2000;
      send_row(2, 0, "R11", 1'b1);

      // R13 rows after earlier rows: all negative scores, one element per block
      fill_vals(3, 7); sc[0] = -4000; sc[1] = -3900; sc[2] = -4100;
      send_row(3, 'b111, "R13", 1'b0);

      // equal scores in two blocks, then a repeat of the single-element row (R13)
      fill_vals(4, 8); sc[0] = 0; sc[1] = 0; sc[2] = 0; sc[3] = 0;
      send_row(4, 'b1010, "R13 R7", 1'b0);
      fill_vals(1, 9); sc[0] = -1234;
      send_row(1, 0, "R13 R12", 1'b1);

      summary();
      $finish;
   end
endmodule